// File: doc/BRIEF.md
# UART DMA Request Generator

This block produces the two level-sensitive DMA request lines of a UART that has a receive path and a transmit path. Each path either has a FIFO or a single holding register. The block reads status from the rest of the UART: FIFO occupancy, holding-register state, the receive trigger level, the receive timeout flag and strobes on writes to the transmit data register. It also holds a small control word. That word sets the request policy and enables the FIFOs, and it carries two self-clearing commands that flush a FIFO.

There are two request policies. The character policy (mode 0) asks for service whenever one character can move. The threshold policy (mode 1) raises a request on a FIFO threshold and keeps it until the FIFO reaches the opposite extreme. The flush commands become one-cycle pulses for the FIFOs. A flush changes the request outputs on the same edge as it produces its pulse. Every output is registered and responds one clock after the edge that samples the cause.

Top module: `uart_dma_req`

## Requirements
- R1: After reset, both request outputs and both flush pulses are 0, and `cfg_rdata` reads 0. This means the policy is mode 0 and the FIFOs are disabled.
- R2: In mode 0 the receive request is 1 one cycle after the receive side holds data, and 0 one cycle after it is empty. With FIFO enable set, data means `rx_fifo_lvl` != 0. With FIFO enable clear, data means `rx_hold_full` = 1.
- R3: In mode 0 the transmit request is set one cycle after the transmit side is empty and is cleared one cycle after any `tx_data_wr` pulse. A write takes priority over the empty condition. Otherwise the request keeps its value. Empty means `tx_fifo_lvl` = 0 with FIFO enable set, and `tx_hold_empty` = 1 with it clear.
- R4: In mode 1 the receive request is set one cycle after `rx_fifo_lvl` >= `rx_trig_lvl` or `rx_timeout` = 1. It holds through lower levels and is cleared only one cycle after `rx_fifo_lvl` = 0. The clear takes priority over the set.
- R5: In mode 1 the transmit request is set one cycle after `tx_fifo_lvl` = 0. It is held until one cycle after `tx_fifo_lvl` = FIFO_DEPTH.
- R6: A write with `cfg_wdata[2]` = 1 gives exactly one cycle of `tx_fifo_flush` in the next cycle. `cfg_wdata[1]` = 1 does the same for `rx_fifo_flush`. A write with those bits at 0 gives no pulse.
- R7: Writing `cfg_we` latches `cfg_wdata[3]` as the mode and `cfg_wdata[0]` as the FIFO enable. The new values apply from the next cycle. `cfg_rdata` returns mode in bit 3 and enable in bit 0, and always returns 0 in bits 2 and 1.
- R8: A transmit flush sets the transmit request in the same cycle as its pulse, in either mode and even with a simultaneous `tx_data_wr`. A receive flush clears the receive request in the same cycle as its pulse.
- R9: In mode 1, `tx_data_wr`, `tx_hold_empty` and `rx_hold_full` have no effect on the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: [3] mode, [2] transmit flush, [1] receive flush, [0] FIFO enable |
| cfg_rdata | output | 4 | Control word readback; flush bits read 0 |
| rx_hold_full | input | 1 | Receive holding register has a character |
| rx_fifo_lvl | input | LVL_W | Receive FIFO occupancy |
| rx_trig_lvl | input | LVL_W | Receive FIFO trigger threshold |
| rx_timeout | input | 1 | Receive timeout flag |
| tx_hold_empty | input | 1 | Transmit holding register is empty |
| tx_fifo_lvl | input | LVL_W | Transmit FIFO occupancy |
| tx_data_wr | input | 1 | Write strobe to the transmit data register |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_fifo_flush | output | 1 | One-cycle receive FIFO flush pulse |
| tx_fifo_flush | output | 1 | One-cycle transmit FIFO flush pulse |

## Verification
Each output of this block is due exactly one clock after the edge that samples its cause. This holds for the request updates, the flush pulses and the control readback, because every one of them passes through a single register. The bench changes inputs only on falling edges. A behavioural model updates on each rising edge from the inputs it sees there. The outputs are compared with the model on the following falling edge, so every comparison lands one register stage after its stimulus. Holding and clearing behaviour is checked by leaving levels unchanged for several cycles and comparing on every one of them.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    localparam int CFG_W          = 4;
    localparam int CFG_FIFO_EN_B  = 0;
    localparam int CFG_RX_CLR_B   = 1;
    localparam int CFG_TX_CLR_B   = 2;
    localparam int CFG_MODE_B     = 3;

    typedef enum logic {
        REQ_CHAR = 1'b0,
        REQ_FIFO = 1'b1
    } req_mode_e;

    typedef struct packed {
        req_mode_e mode;
        logic      fifo_en;
        logic      tx_flush;
        logic      rx_flush;
    } cfg_state_t;

    typedef struct packed {
        logic req;
    } req_state_t;

endpackage

// File: rtl/uart_dma_cfg.sv
module uart_dma_cfg
    import uart_dma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output req_mode_e            mode,
    output logic                 fifo_en,
    output logic                 tx_flush_cmd,
    output logic                 rx_flush_cmd,
    output logic                 tx_flush_pulse,
    output logic                 rx_flush_pulse
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        tx_flush_cmd  = cfg_we & cfg_wdata[CFG_TX_CLR_B];
        rx_flush_cmd  = cfg_we & cfg_wdata[CFG_RX_CLR_B];
        st_d.tx_flush = tx_flush_cmd;
        st_d.rx_flush = rx_flush_cmd;
        if (cfg_we) begin
            st_d.mode    = req_mode_e'(cfg_wdata[CFG_MODE_B]);
            st_d.fifo_en = cfg_wdata[CFG_FIFO_EN_B];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: REQ_CHAR, fifo_en: 1'b0, tx_flush: 1'b0, rx_flush: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata                = '0;
        cfg_rdata[CFG_MODE_B]    = st_q.mode;
        cfg_rdata[CFG_FIFO_EN_B] = st_q.fifo_en;
    end

    assign mode           = st_q.mode;
    assign fifo_en        = st_q.fifo_en;
    assign tx_flush_pulse = st_q.tx_flush;
    assign rx_flush_pulse = st_q.rx_flush;

    AST_TX_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[CFG_TX_CLR_B]) |=> tx_flush_pulse) else $error("tx flush"); // R6
    AST_NO_SPURIOUS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && (cfg_wdata[CFG_TX_CLR_B] || cfg_wdata[CFG_RX_CLR_B]))
        |=> !(tx_flush_pulse || rx_flush_pulse)) else $error("spurious flush"); // R6
    AST_CFG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[CFG_MODE_B] == $past(cfg_wdata[CFG_MODE_B]))) else $error("mode latch"); // R7

endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
    import uart_dma_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  req_mode_e        mode,
    input  logic             fifo_en,
    input  logic             flush_cmd,
    input  logic             hold_full,
    input  logic [LVL_W-1:0] fifo_lvl,
    input  logic [LVL_W-1:0] trig_lvl,
    input  logic             timeout,
    output logic             req
);

    req_state_t st_d, st_q;
    logic       fifo_empty;
    logic       char_avail;
    logic       thresh_hit;

    always_comb begin
        fifo_empty = (fifo_lvl == '0);
        char_avail = fifo_en ? !fifo_empty : hold_full;
        thresh_hit = (fifo_lvl >= trig_lvl) || timeout;
        st_d       = st_q;
        if (flush_cmd) begin
            st_d.req = 1'b0;
        end else if (mode == REQ_CHAR) begin
            st_d.req = char_avail;
        end else if (fifo_empty) begin
            st_d.req = 1'b0;
        end else if (thresh_hit) begin
            st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    AST_RX_CHAR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_CHAR && !flush_cmd) |=> (req == $past(fifo_en ? (fifo_lvl != '0) : hold_full)))
        else $error("rx char"); // R2
    AST_RX_THRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_FIFO && req && fifo_lvl != '0 && !flush_cmd) |=> req) else $error("rx hold"); // R4
    AST_RX_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        flush_cmd |=> !req) else $error("rx flush"); // R8

endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  req_mode_e        mode,
    input  logic             fifo_en,
    input  logic             flush_cmd,
    input  logic             hold_empty,
    input  logic [LVL_W-1:0] fifo_lvl,
    input  logic             data_wr,
    output logic             req
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    req_state_t st_d, st_q;
    logic       fifo_empty;
    logic       fifo_full;
    logic       char_room;

    always_comb begin
        fifo_empty = (fifo_lvl == '0);
        fifo_full  = (fifo_lvl == FULL_LVL);
        char_room  = fifo_en ? fifo_empty : hold_empty;
        st_d       = st_q;
        if (flush_cmd) begin
            st_d.req = 1'b1;
        end else if (mode == REQ_CHAR) begin
            if (data_wr) begin
                st_d.req = 1'b0;
            end else if (char_room) begin
                st_d.req = 1'b1;
            end
        end else if (fifo_empty) begin
            st_d.req = 1'b1;
        end else if (fifo_full) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    AST_TX_WR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_CHAR && data_wr && !flush_cmd) |=> !req) else $error("tx write"); // R3
    AST_TX_THRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_FIFO && req && fifo_lvl != FULL_LVL) |=> req) else $error("tx hold"); // R5
    AST_TX_FLUSH_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_cmd |=> req) else $error("tx flush"); // R8

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import uart_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_wdata,
    output logic [3:0]       cfg_rdata,
    input  logic             rx_hold_full,
    input  logic [LVL_W-1:0] rx_fifo_lvl,
    input  logic [LVL_W-1:0] rx_trig_lvl,
    input  logic             rx_timeout,
    input  logic             tx_hold_empty,
    input  logic [LVL_W-1:0] tx_fifo_lvl,
    input  logic             tx_data_wr,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             rx_fifo_flush,
    output logic             tx_fifo_flush
);

    req_mode_e mode;
    logic      fifo_en;
    logic      tx_flush_cmd;
    logic      rx_flush_cmd;

    uart_dma_cfg u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .mode           (mode),
        .fifo_en        (fifo_en),
        .tx_flush_cmd   (tx_flush_cmd),
        .rx_flush_cmd   (rx_flush_cmd),
        .tx_flush_pulse (tx_fifo_flush),
        .rx_flush_pulse (rx_fifo_flush)
    );

    uart_dma_rx_req #(.LVL_W(LVL_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .fifo_en   (fifo_en),
        .flush_cmd (rx_flush_cmd),
        .hold_full (rx_hold_full),
        .fifo_lvl  (rx_fifo_lvl),
        .trig_lvl  (rx_trig_lvl),
        .timeout   (rx_timeout),
        .req       (rx_dma_req)
    );

    uart_dma_tx_req #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .fifo_en    (fifo_en),
        .flush_cmd  (tx_flush_cmd),
        .hold_empty (tx_hold_empty),
        .fifo_lvl   (tx_fifo_lvl),
        .data_wr    (tx_data_wr),
        .req        (tx_dma_req)
    );

    AST_FLUSH_ONEHOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_fifo_flush) |-> tx_dma_req) else $error("flush/req"); // R8
    AST_MODE1_IGNORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == REQ_FIFO && !tx_flush_cmd && tx_fifo_lvl != '0 && tx_fifo_lvl != LVL_W'(FIFO_DEPTH))
        |=> $stable(tx_dma_req)) else $error("mode1 tx"); // R9

endmodule

// File: tb/uart_dma_req_bench.sv
module uart_dma_req_bench;

    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_wdata = '0;
    logic [3:0]    cfg_rdata;
    logic          rx_hold_full = 1'b0;
    logic [LW-1:0] rx_fifo_lvl = '0;
    logic [LW-1:0] rx_trig_lvl = '0;
    logic          rx_timeout = 1'b0;
    logic          tx_hold_empty = 1'b0;
    logic [LW-1:0] tx_fifo_lvl = '0;
    logic          tx_data_wr = 1'b0;
    logic          rx_dma_req, tx_dma_req, rx_fifo_flush, tx_fifo_flush;

    uart_dma_req #(.FIFO_DEPTH(DEPTH)) u_uart_dma_req (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rx_hold_full(rx_hold_full), .rx_fifo_lvl(rx_fifo_lvl), .rx_trig_lvl(rx_trig_lvl),
        .rx_timeout(rx_timeout), .tx_hold_empty(tx_hold_empty), .tx_fifo_lvl(tx_fifo_lvl),
        .tx_data_wr(tx_data_wr), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_fifo_flush(rx_fifo_flush), .tx_fifo_flush(tx_fifo_flush)
    );

    always #10 clk = ~clk;

    // behavioural reference
    bit m_mode, m_en, m_rxq, m_txq, m_rxf, m_txf;
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string tag   = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_en = 0; m_rxq = 0; m_txq = 0; m_rxf = 0; m_txf = 0;
        end else begin
            int rl, tl, tr;
            bit txcmd, rxcmd;
            rl = int'(rx_fifo_lvl); tl = int'(tx_fifo_lvl); tr = int'(rx_trig_lvl);
            txcmd = cfg_we && cfg_wdata[2];
            rxcmd = cfg_we && cfg_wdata[1];
            if (rxcmd) m_rxq = 0;
            else if (!m_mode) m_rxq = m_en ? (rl != 0) : rx_hold_full;
            else if (rl == 0) m_rxq = 0;
            else if (rl >= tr || rx_timeout) m_rxq = 1;
            if (txcmd) m_txq = 1;
            else if (!m_mode) begin
                if (tx_data_wr) m_txq = 0;
                else if (m_en ? (tl == 0) : tx_hold_empty) m_txq = 1;
            end else if (tl == 0) m_txq = 1;
            else if (tl == DEPTH) m_txq = 0;
            m_txf = txcmd;
            m_rxf = rxcmd;
            if (cfg_we) begin m_mode = cfg_wdata[3]; m_en = cfg_wdata[0]; end
        end
    end

    task automatic tick();
        logic [3:0] exp_rd;
        @(negedge clk);
        exp_rd = {m_mode, 2'b00, m_en};
        n_checks++;
        if (rx_dma_req !== m_rxq || tx_dma_req !== m_txq || rx_fifo_flush !== m_rxf ||
            tx_fifo_flush !== m_txf || cfg_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s: got rx=%b tx=%b rfl=%b tfl=%b rd=%h exp rx=%b tx=%b rfl=%b tfl=%b rd=%h",
                     tag, rx_dma_req, tx_dma_req, rx_fifo_flush, tx_fifo_flush, cfg_rdata,
                     m_rxq, m_txq, m_rxf, m_txf, exp_rd);
        end
    endtask

    task automatic wr_cfg(input bit mode, input bit txc, input bit rxc, input bit en);
        cfg_we = 1; cfg_wdata = {mode, txc, rxc, en};
        tick();
        cfg_we = 0; cfg_wdata = '0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        tick(); tick();
        rst_n = 1;
        tag = "R1"; run(2);

        tag = "R7"; wr_cfg(0, 0, 0, 1); run(1);
        wr_cfg(1, 0, 0, 0); run(1);
        wr_cfg(0, 0, 0, 1); run(1);

        tag = "R2"; rx_fifo_lvl = 3; run(2);
        rx_fifo_lvl = 0; run(2);
        rx_fifo_lvl = 1; run(1);
        wr_cfg(0, 0, 0, 0); rx_fifo_lvl = 0;
        rx_hold_full = 1; run(2);
        rx_hold_full = 0; run(2);

        tag = "R3"; tx_hold_empty = 1; run(2);
        tx_data_wr = 1; run(1); tx_data_wr = 0;
        tx_hold_empty = 0; run(3);
        tx_hold_empty = 1; run(2);
        wr_cfg(0, 0, 0, 1); tx_fifo_lvl = 4; run(1);
        tx_data_wr = 1; run(1); tx_data_wr = 0; run(2);
        tx_fifo_lvl = 0; run(2);

        tag = "R6"; wr_cfg(0, 1, 0, 1); run(2);
        wr_cfg(0, 0, 1, 1); run(2);
        wr_cfg(0, 0, 0, 1); run(2);

        tag = "R8"; tx_fifo_lvl = 6; tx_data_wr = 1; run(1); tx_data_wr = 0; run(1);
        tx_data_wr = 1; wr_cfg(0, 1, 0, 1); tx_data_wr = 0; run(2);
        rx_fifo_lvl = 5; run(2); wr_cfg(0, 0, 1, 1); rx_fifo_lvl = 0; run(1);

        tag = "R4"; wr_cfg(1, 0, 0, 1); rx_trig_lvl = 8;
        rx_fifo_lvl = 4; run(3);
        rx_fifo_lvl = 8; run(2);
        rx_fifo_lvl = 3; run(3);
        rx_fifo_lvl = 0; run(2);
        rx_fifo_lvl = 2; rx_timeout = 1; run(1); rx_timeout = 0; run(3);
        rx_fifo_lvl = 0; rx_timeout = 1; run(2); rx_timeout = 0;
        rx_fifo_lvl = LW'(DEPTH); run(1); wr_cfg(1, 0, 1, 1); run(2);

        tag = "R5"; tx_fifo_lvl = 0; run(2);
        tx_fifo_lvl = 5; run(3);
        tx_fifo_lvl = LW'(DEPTH); run(2);
        tx_fifo_lvl = 10; run(3);
        wr_cfg(1, 1, 0, 1); run(2);

        tag = "R9"; tx_fifo_lvl = 7; rx_fifo_lvl = 0;
        tx_data_wr = 1; tx_hold_empty = 1; rx_hold_full = 1; run(3);
        tx_data_wr = 0; tx_fifo_lvl = LW'(DEPTH); run(2);
        tx_fifo_lvl = 9; tx_hold_empty = 1; run(3);

        tag = "R1"; rst_n = 0; run(1); rst_n = 1; run(1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule